// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block is the master side of a single-lane serial flash link. Software loads three holding registers: a 24-bit address, a 32-bit data word and a timing word. It then writes a command word. The block drives one of several active-low chip selects, the serial clock and the outgoing data line through up to four phases: opcode, address, dummy and data. On read commands it collects the incoming data line into the data word. Busy and error flags let software know when the data word is valid and when a command was refused.

A keep-selected flag leaves the chip select asserted after a command ends, so several commands can form one framed flash transaction. A command that arrives while the select is still held skips its opcode and runs only the phases whose lengths are nonzero. A held command with every length zero and the flag clear only closes the frame. The serial clock idles high, as in SPI mode 3. Its period, the positions of its falling and rising edges, and the point at which the incoming line is sampled are all set in core clock cycles.

Top module: `sfseq_top`

## Requirements
- R1: The command word holds the opcode in bits 7:0, the write flag in bit 8, the data byte count in bits 11:9, the keep-selected flag in bit 15, the dummy byte count in bits 19:16, the address byte count in bits 22:20 and the chip-select index in bits 26:24. A command accepted with no frame open sends the opcode first, then address, dummy and data bytes, each byte most significant bit first. Each bit is presented on `mosi` before the rising `sck` edge that captures it.
- R2: The address phase sends the low N bytes of the 24-bit address register, most significant of those bytes first, where N is 0 to 3.
- R3: The dummy phase lasts 0 to 15 bytes, with `mosi` held at 0.
- R4: A write command sends 0 to 4 bytes from the data register, starting with bits 7:0 and moving up a byte at a time. The data register keeps its value.
- R5: A read command clears the data register and then stores the k-th received byte in bits 8k+7:8k. Each byte is received most significant bit first. Bytes that are not received stay 0, and `rdata` is final when `busy` is low.
- R6: With keep-selected set, the chip select stays asserted after the command ends. The next command then sends no opcode.
- R7: A command issued with a frame open, all three lengths zero and keep-selected clear produces no `sck` edge and only releases the chip select.
- R8: `busy` rises on the cycle after a command is accepted and falls when the command completes. When keep-selected is clear, the chip select is released at that same edge.
- R9: A command write is refused and sets `err` in three cases: while `busy` is high, with an address count above 3, or with a data count above 4. A refused command produces no `sck` activity. `err_clr` clears `err`, and a new error in the same cycle wins.
- R10: `sck` is high whenever no chip select is active. The timing word holds the bit period in bits 3:0 (0 means 16), the fall position in bits 15:12, the rise position in bits 11:8 and the `miso` sample position in bits 19:16. Rising edges are one period apart. The reset value is period 4, fall 0, rise 2, sample 2.
- R11: Writes to the address, data and timing registers while `busy` is high are ignored.
- R12: `cs_n` has one active-low line per chip-select index, and at most one line is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wd | input | 32 | Command word |
| adr_we | input | 1 | Address register write strobe |
| adr_wd | input | 24 | Address value |
| dat_we | input | 1 | Data register write strobe |
| dat_wd | input | 32 | Data value |
| tim_we | input | 1 | Timing register write strobe |
| tim_wd | input | 20 | Timing value |
| err_clr | input | 1 | Clears the error flag |
| busy | output | 1 | Command in progress |
| err | output | 1 | Sticky error flag |
| rdata | output | 32 | Data register contents |
| sck | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 8 | Active-low chip selects |

## Verification
A wrong phase or byte count appears at once as a bit stream with the wrong length or wrong contents. The bench captures every bit on the rising serial clock and compares it when the command completes. A wrong receive index or sample point corrupts `rdata` as soon as `busy` falls. A stale held-select flag changes the opcode count and the `cs_n` level on the very next command. Refusal logic is checked from `err` one cycle after the write and from the unchanged register contents after the running command ends.

// File: rtl/sfseq_pkg.sv
package sfseq_pkg;

    typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_FIN} st_e;
    typedef enum logic [2:0] {PH_OPC, PH_ADR, PH_DUM, PH_DAT, PH_END} ph_e;

    localparam int ADR_W     = 24;
    localparam int DAT_W     = 32;
    localparam int TIM_W     = 20;
    localparam int ADR_MAX   = ADR_W / 8;
    localparam int DAT_MAX   = DAT_W / 8;

    // phase that follows cur, skipping empty ones
    function automatic ph_e ph_after(ph_e cur, logic [1:0] alen,
                                     logic [3:0] dum, logic [2:0] dlen);
        ph_e r;
        r = PH_END;
        case (cur)
            PH_OPC: begin
                if (alen != 2'd0)     r = PH_ADR;
                else if (dum != 4'd0) r = PH_DUM;
                else if (dlen != 3'd0) r = PH_DAT;
            end
            PH_ADR: begin
                if (dum != 4'd0)       r = PH_DUM;
                else if (dlen != 3'd0) r = PH_DAT;
            end
            PH_DUM: begin
                if (dlen != 3'd0) r = PH_DAT;
            end
            default: r = PH_END;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sfseq_clkgen.sv
module sfseq_clkgen #(
    parameter int TIM_W = 20,
    parameter logic [TIM_W-1:0] TIM_RST = 20'h20204
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tim_we,
    input  logic [TIM_W-1:0] tim_wd,
    input  logic             lock,
    input  logic             run,
    output logic             sck,
    output logic             bit_end,
    output logic             smp
);
    typedef struct packed {
        logic [TIM_W-1:0] tim;
        logic [3:0]       cnt;
        logic             sck;
    } ck_t;

    ck_t q, d;
    logic [3:0] per, per_m1, pos_f, pos_r, pos_s;
    logic [3:0] unused_tim;

    assign per        = q.tim[3:0];
    assign unused_tim = q.tim[7:4];
    assign pos_r      = q.tim[11:8];
    assign pos_f      = q.tim[15:12];
    assign pos_s      = q.tim[19:16];
    assign per_m1     = per - 4'd1;

    assign bit_end = run && (q.cnt == per_m1);
    assign smp     = run && (q.cnt == pos_s);
    assign sck     = q.sck;

    always_comb begin
        d = q;
        if (tim_we && !lock) d.tim = tim_wd;
        if (!run) begin
            d.cnt = 4'd0;
            d.sck = 1'b1;
        end else begin
            d.cnt = bit_end ? 4'd0 : q.cnt + 4'd1;
            if (q.cnt == pos_f)      d.sck = 1'b0;
            else if (q.cnt == pos_r) d.sck = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.tim <= TIM_RST;
            q.cnt <= 4'd0;
            q.sck <= 1'b1;
        end else begin
            q <= d;
        end
    end

    // R10
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && per != 4'd0) |-> (q.cnt < per));

    // R11
    tim_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(q.tim));

endmodule

// File: rtl/sfseq_csdec.sv
module sfseq_csdec #(
    parameter int CS_W = 3,
    localparam int NCS = 1 << CS_W
) (
    input  logic            act,
    input  logic [CS_W-1:0] sel,
    output logic [NCS-1:0]  cs_n
);
    for (genvar i = 0; i < NCS; i++) begin : g_line
        assign cs_n[i] = !(act && (sel == CS_W'(i)));
    end
endmodule

// File: rtl/sfseq_ctrl.sv
module sfseq_ctrl
    import sfseq_pkg::*;
#(
    parameter int CS_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [31:0]      cmd_wd,
    input  logic             adr_we,
    input  logic [ADR_W-1:0] adr_wd,
    input  logic             dat_we,
    input  logic [DAT_W-1:0] dat_wd,
    input  logic             err_clr,
    input  logic             bit_end,
    input  logic             smp,
    input  logic             miso,
    output logic             run,
    output logic             busy,
    output logic             err,
    output logic [DAT_W-1:0] rdata,
    output logic             mosi,
    output logic             cs_act,
    output logic [CS_W-1:0]  cs_sel
);
    typedef struct packed {
        st_e              st;
        ph_e              ph;
        logic [3:0]       left;
        logic [2:0]       bitn;
        logic [7:0]       sh;
        logic [7:0]       rx;
        logic [ADR_W-1:0] asr;
        logic [DAT_W-1:0] wsr;
        logic [DAT_W-1:0] dat;
        logic [ADR_W-1:0] adr;
        logic [1:0]       ridx;
        logic [1:0]       alen;
        logic [3:0]       dum;
        logic [2:0]       dlen;
        logic             wr;
        logic             keep;
        logic             held;
        logic [CS_W-1:0]  sel;
        logic             pend;
        logic             err;
    } sq_t;

    sq_t q, n;

    // command word fields
    logic [7:0]      c_opc;
    logic            c_wr, c_keep;
    logic [2:0]      c_dlen, c_alen;
    logic [3:0]      c_dum;
    logic [CS_W-1:0] c_sel;
    logic            c_bad;
    logic [8:0]      unused_cmd;

    assign c_opc      = cmd_wd[7:0];
    assign c_wr       = cmd_wd[8];
    assign c_dlen     = cmd_wd[11:9];
    assign c_keep     = cmd_wd[15];
    assign c_dum      = cmd_wd[19:16];
    assign c_alen     = cmd_wd[22:20];
    assign c_sel      = cmd_wd[24 +: CS_W];
    assign unused_cmd = {cmd_wd[31:24+CS_W], cmd_wd[23], cmd_wd[14:12]};
    assign c_bad      = (c_alen > 3'(ADR_MAX)) || (c_dlen > 3'(DAT_MAX));

    logic [7:0] rx_now;
    logic       load, fresh;
    ph_e        tp;

    always_comb begin
        n      = q;
        load   = 1'b0;
        fresh  = 1'b0;
        tp     = PH_END;
        rx_now = smp ? {q.rx[6:0], miso} : q.rx;
        if (smp) n.rx = rx_now;

        if (!q.pend) begin
            if (adr_we) n.adr = adr_wd;
            if (dat_we) n.dat = dat_wd;
        end

        if (err_clr) n.err = 1'b0;
        if (cmd_we && (q.pend || c_bad)) n.err = 1'b1;

        case (q.st)
            ST_IDLE: begin
                if (cmd_we && !c_bad) begin
                    n.pend = 1'b1;
                    n.alen = c_alen[1:0];
                    n.dum  = c_dum;
                    n.dlen = c_dlen;
                    n.wr   = c_wr;
                    n.keep = c_keep;
                    n.sel  = c_sel;
                    n.held = 1'b1;
                    n.ridx = 2'd0;
                    n.bitn = 3'd0;
                    n.wsr  = n.dat;
                    if (!c_wr) n.dat = '0;
                    case (c_alen[1:0])
                        2'd1:    n.asr = {n.adr[7:0], 16'h0};
                        2'd2:    n.asr = {n.adr[15:0], 8'h0};
                        default: n.asr = n.adr;
                    endcase
                    tp    = q.held ? ph_after(PH_OPC, c_alen[1:0], c_dum, c_dlen)
                                   : PH_OPC;
                    fresh = 1'b1;
                    load  = 1'b1;
                end
            end
            ST_SHIFT: begin
                if (bit_end) begin
                    if (q.bitn == 3'd7) begin
                        if (q.ph == PH_DAT && !q.wr) begin
                            n.dat[{q.ridx, 3'b000} +: 8] = rx_now;
                            n.ridx = q.ridx + 2'd1;
                        end
                        n.bitn = 3'd0;
                        load   = 1'b1;
                        if (q.left > 4'd1) begin
                            tp = q.ph;
                        end else begin
                            tp    = ph_after(q.ph, q.alen, q.dum, q.dlen);
                            fresh = 1'b1;
                        end
                    end else begin
                        n.bitn = q.bitn + 3'd1;
                        n.sh   = {q.sh[6:0], 1'b0};
                    end
                end
            end
            ST_FIN: begin
                n.st   = ST_IDLE;
                n.pend = 1'b0;
                if (!q.keep) n.held = 1'b0;
            end
            default: n.st = ST_IDLE;
        endcase

        if (load) begin
            if (tp == PH_END) begin
                n.st = ST_FIN;
            end else begin
                n.st = ST_SHIFT;
                n.ph = tp;
                if (fresh) begin
                    case (tp)
                        PH_ADR:  n.left = {2'b00, n.alen};
                        PH_DUM:  n.left = n.dum;
                        PH_DAT:  n.left = {1'b0, n.dlen};
                        default: n.left = 4'd1;
                    endcase
                end else begin
                    n.left = q.left - 4'd1;
                end
                case (tp)
                    PH_OPC: n.sh = c_opc;
                    PH_ADR: begin
                        n.sh  = n.asr[ADR_W-1 -: 8];
                        n.asr = {n.asr[ADR_W-9:0], 8'h0};
                    end
                    PH_DAT: begin
                        if (n.wr) begin
                            n.sh  = n.wsr[7:0];
                            n.wsr = {8'h0, n.wsr[DAT_W-1:8]};
                        end else begin
                            n.sh = 8'h0;
                        end
                    end
                    default: n.sh = 8'h0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign run    = (q.st == ST_SHIFT);
    assign busy   = q.pend;
    assign err    = q.err;
    assign rdata  = q.dat;
    assign mosi   = run ? q.sh[7] : 1'b0;
    assign cs_act = q.held;
    assign cs_sel = q.sel;

    // R3
    dummy_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && q.ph == PH_DUM) |-> !mosi);

    // R9
    busy_cmd_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && q.pend) |=> q.err);

    // R8
    pend_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.pend) |-> ($past(q.st) == ST_FIN));

    // R11
    dat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.pend && q.wr) |=> $stable(q.dat));

endmodule

// File: rtl/sfseq_top.sv
module sfseq_top #(
    parameter int CS_W = 3,
    parameter logic [19:0] TIM_RST = 20'h20204,
    localparam int NCS = 1 << CS_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_we,
    input  logic [31:0]    cmd_wd,
    input  logic           adr_we,
    input  logic [23:0]    adr_wd,
    input  logic           dat_we,
    input  logic [31:0]    dat_wd,
    input  logic           tim_we,
    input  logic [19:0]    tim_wd,
    input  logic           err_clr,
    output logic           busy,
    output logic           err,
    output logic [31:0]    rdata,
    output logic           sck,
    output logic           mosi,
    input  logic           miso,
    output logic [NCS-1:0] cs_n
);
    logic            run, bit_end, smp, cs_act;
    logic [CS_W-1:0] cs_sel;

    sfseq_clkgen #(.TIM_W(20), .TIM_RST(TIM_RST)) u_clk (
        .clk     (clk),
        .rst_n   (rst_n),
        .tim_we  (tim_we),
        .tim_wd  (tim_wd),
        .lock    (busy),
        .run     (run),
        .sck     (sck),
        .bit_end (bit_end),
        .smp     (smp)
    );

    sfseq_ctrl #(.CS_W(CS_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_we  (cmd_we),
        .cmd_wd  (cmd_wd),
        .adr_we  (adr_we),
        .adr_wd  (adr_wd),
        .dat_we  (dat_we),
        .dat_wd  (dat_wd),
        .err_clr (err_clr),
        .bit_end (bit_end),
        .smp     (smp),
        .miso    (miso),
        .run     (run),
        .busy    (busy),
        .err     (err),
        .rdata   (rdata),
        .mosi    (mosi),
        .cs_act  (cs_act),
        .cs_sel  (cs_sel)
    );

    sfseq_csdec #(.CS_W(CS_W)) u_cs (
        .act  (cs_act),
        .sel  (cs_sel),
        .cs_n (cs_n)
    );

    // R12
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R10
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&cs_n) |-> sck);

endmodule

// File: tb/sfseq_tb.sv
`timescale 1ns/1ps
module sfseq_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0, adr_we = 1'b0, dat_we = 1'b0, tim_we = 1'b0, err_clr = 1'b0;
    logic [31:0] cmd_wd = '0, dat_wd = '0;
    logic [23:0] adr_wd = '0;
    logic [19:0] tim_wd = '0;
    logic        busy, err, sck, mosi;
    logic        miso = 1'b0;
    logic [31:0] rdata;
    logic [7:0]  cs_n;

    int total = 0, bad = 0;
    int cyc = 0;

    bit cap [0:255];
    bit ex  [0:255];
    int ncap = 0, nfall = 0, nrise = 0, ivbad = 0, per_exp = 4;
    time tlast = 0;

    always #10 clk = ~clk;

    sfseq_top dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wd(cmd_wd),
        .adr_we(adr_we), .adr_wd(adr_wd), .dat_we(dat_we), .dat_wd(dat_wd),
        .tim_we(tim_we), .tim_wd(tim_wd), .err_clr(err_clr), .busy(busy),
        .err(err), .rdata(rdata), .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    function automatic bit sb(int k);
        return ((k * 13 + (k >> 2)) % 3) == 0;
    endfunction

    always @(posedge sck) begin
        if (ncap < 256) cap[ncap] = mosi;
        ncap++;
        if (nrise > 0 && ($time - tlast) / 20 != per_exp) ivbad++;
        tlast = $time;
        nrise++;
    end

    always @(negedge sck) begin
        miso = sb(nfall);
        nfall++;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog act=%0d exp=done", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [7:0] opc, input bit wr, input int dlen,
                                       input bit keep, input int dum, input int alen,
                                       input logic [2:0] sel);
        return {5'b0, sel, 1'b0, 3'(alen), 4'(dum), keep, 3'b0, 3'(dlen), wr, opc};
    endfunction

    task automatic pulse_cmd(input logic [31:0] w);
        @(negedge clk);
        cmd_we = 1'b1;
        cmd_wd = w;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic set_regs(input logic [23:0] a, input logic [31:0] d);
        @(negedge clk);
        adr_we = 1'b1; adr_wd = a;
        dat_we = 1'b1; dat_wd = d;
        @(negedge clk);
        adr_we = 1'b0; dat_we = 1'b0;
    endtask

    task automatic clr_cap();
        ncap = 0; nfall = 0; nrise = 0; ivbad = 0;
    endtask

    // builds expected stream, returns bit count
    task automatic build(input logic [7:0] opc, input int alen, input int dum, input int dlen,
                         input bit wr, input bit held, input logic [23:0] a,
                         input logic [31:0] d, output int ne);
        int k = 0;
        if (!held) for (int b = 7; b >= 0; b--) begin ex[k] = opc[b]; k++; end
        for (int i = alen - 1; i >= 0; i--)
            for (int b = 7; b >= 0; b--) begin ex[k] = a[8*i+b]; k++; end
        for (int i = 0; i < dum * 8; i++) begin ex[k] = 1'b0; k++; end
        for (int j = 0; j < dlen; j++)
            for (int b = 7; b >= 0; b--) begin ex[k] = wr ? d[8*j+b] : 1'b0; k++; end
        ne = k;
    endtask

    task automatic cmp_stream(input int ne, input string rq);
        int nb = 0;
        chk(ncap == ne, rq, "bit count", ncap, ne);
        for (int i = 0; i < ne && i < ncap; i++) if (cap[i] != ex[i]) nb++;
        chk(nb == 0, rq, "mismatched bits", nb, 0);
    endtask

    task automatic run_cmd(input logic [7:0] opc, input int alen, input int dum, input int dlen,
                           input bit wr, input bit keep, input bit held, input logic [2:0] sel,
                           input logic [23:0] a, input logic [31:0] d, input string rq);
        int ne, start;
        logic [31:0] exd;
        set_regs(a, d);
        clr_cap();
        pulse_cmd(mk(opc, wr, dlen, keep, dum, alen, sel));
        chk(busy == 1'b1, "R8", "busy after accept", busy, 1);
        wait_idle();
        build(opc, alen, dum, dlen, wr, held, a, d, ne);
        cmp_stream(ne, rq);
        start = (held ? 0 : 8) + 8 * alen + 8 * dum;
        exd = '0;
        if (wr) exd = d;
        else
            for (int j = 0; j < dlen; j++)
                for (int i = 0; i < 8; i++) exd[8*j+7-i] = sb(start + 8*j + i);
        chk(rdata == exd, wr ? "R4" : "R5", "data register", rdata, exd);
        if (keep) chk(cs_n == ~(8'h1 << sel), "R6", "cs held", cs_n, ~(8'h1 << sel));
        else      chk(cs_n == 8'hFF, "R8", "cs released", cs_n, 8'hFF);
        chk(ivbad == 0, "R10", "rise interval errors", ivbad, 0);
    endtask

    initial begin
        int ne;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && err == 0, "R8", "reset flags", {busy, err}, 0);
        chk(sck == 1'b1, "R10", "reset sck", sck, 1);
        chk(cs_n == 8'hFF, "R12", "reset cs", cs_n, 8'hFF);
        chk(rdata == 32'h0, "R5", "reset data", rdata, 0);

        // sweep of phase lengths, direction, select
        for (int a = 0; a <= 3; a++)
            for (int dm = 0; dm <= 2; dm++)
                for (int l = 0; l <= 4; l++)
                    for (int w = 0; w <= 1; w++)
                        run_cmd(8'h90 ^ 8'(a*37 + dm*11 + l*5 + w), a, dm, l, w[0], 1'b0, 1'b0,
                                3'((a + dm + l + w) % 8), 24'hA5C3_96 ^ 24'(a * 4099 + l * 77),
                                32'h1234_5678 ^ 32'(l * 32'h0101_0101 + dm), "R1/R2/R3/R4");

        // long dummy phase
        run_cmd(8'hEB, 3, 15, 4, 1'b0, 1'b0, 1'b0, 3'd7, 24'h0F1E2D, 32'h0, "R3");

        // held frame: open, continue without opcode, close
        run_cmd(8'h0B, 3, 1, 0, 1'b1, 1'b1, 1'b0, 3'd5, 24'h123456, 32'h0, "R6");
        run_cmd(8'h0B, 0, 0, 2, 1'b0, 1'b1, 1'b1, 3'd5, 24'h0, 32'h0, "R6");
        run_cmd(8'hFF, 1, 0, 3, 1'b1, 1'b1, 1'b1, 3'd5, 24'h00_00C7, 32'h00AB_CDEF, "R6");
        run_cmd(8'h00, 0, 0, 0, 1'b0, 1'b0, 1'b1, 3'd5, 24'h0, 32'h0, "R7");
        chk(nfall == 0, "R7", "close sck edges", nfall, 0);

        // refusal while busy, register lock
        set_regs(24'h345678, 32'hCAFE_F00D);
        clr_cap();
        pulse_cmd(mk(8'h02, 1'b1, 4, 1'b0, 0, 3, 3'd1));
        cmd_we = 1'b1; cmd_wd = mk(8'h03, 1'b0, 4, 1'b0, 2, 3, 3'd2);
        adr_we = 1'b1; adr_wd = 24'h111111;
        dat_we = 1'b1; dat_wd = 32'h2222_2222;
        @(negedge clk);
        cmd_we = 1'b0; adr_we = 1'b0; dat_we = 1'b0;
        chk(err == 1'b1, "R9", "err on busy write", err, 1);
        wait_idle();
        build(8'h02, 3, 0, 4, 1'b1, 1'b0, 24'h345678, 32'hCAFE_F00D, ne);
        cmp_stream(ne, "R9");
        chk(rdata == 32'hCAFE_F00D, "R11", "data kept", rdata, 32'hCAFE_F00D);
        clr_cap();
        pulse_cmd(mk(8'h05, 1'b0, 0, 1'b0, 0, 3, 3'd0));
        wait_idle();
        build(8'h05, 3, 0, 0, 1'b0, 1'b0, 24'h345678, 32'h0, ne);
        cmp_stream(ne, "R11");

        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
        chk(err == 1'b0, "R9", "err cleared", err, 0);

        // invalid lengths
        clr_cap();
        pulse_cmd(mk(8'h06, 1'b0, 1, 1'b0, 0, 5, 3'd0));
        chk(err == 1'b1 && busy == 1'b0, "R9", "bad alen", {err, busy}, 2);
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
        @(negedge clk);
        err_clr = 1'b1; cmd_we = 1'b1; cmd_wd = mk(8'h06, 1'b0, 6, 1'b0, 0, 1, 3'd0);
        @(negedge clk);
        err_clr = 1'b0; cmd_we = 1'b0;
        chk(err == 1'b1 && busy == 1'b0, "R9", "bad dlen, set wins", {err, busy}, 2);
        repeat (4) @(negedge clk);
        chk(nfall == 0 && cs_n == 8'hFF, "R9", "no activity", nfall, 0);
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;

        // second timing: period 6, fall 1, rise 4, sample 5
        @(negedge clk); tim_we = 1'b1; tim_wd = 20'h51406;
        @(negedge clk); tim_we = 1'b0;
        per_exp = 6;
        for (int l = 1; l <= 4; l++)
            run_cmd(8'h3B, l - 1, l % 2, l, 1'b0, 1'b0, 1'b0, 3'(l), 24'h55AA33, 32'h0, "R10");
        run_cmd(8'h32, 2, 0, 4, 1'b1, 1'b0, 1'b0, 3'd6, 24'h00BEEF, 32'h8040_2010, "R10");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule